// File: doc/BRIEF.md
# Trigger Type Lookup Encoder

This block turns raw trigger lines into a single event strobe with a 10-bit event-type code. It takes 75 synchronous trigger lines in three groups: a 30-line backplane group, a 30-line external group and a 15-line front-panel group. It also takes a software-issued trigger that carries its own type. Each line has its own enable bit and its own prescaler. It also has a saturating counter that records every enabled rising edge. These counters can be read through a select/value port.

After prescaling, each group's pattern is cut into 5-bit slices. Each slice addresses its own 32-entry table, which software loads. The codes of all non-zero slices in a group are ORed into that group's code. A fixed-priority selector then picks the code of one source.

Software writes control, per-line configuration, counter clears and table contents through a single write port. It loads the tables while a run bit is clear. Once data taking starts, table writes are locked out. The design is one synchronous clock domain, targeted at 250 MHz.

Top module: `trig_type_encoder`

## Requirements
- R1: After reset, `evt_valid` is 0, every counter reads 0, every line is disabled and the run bit is clear.
- R2: A disabled line produces no trigger and its counter does not move. A line is enabled by writing address `0x100+i` with `wr_data[0]=1`, where `wr_data[15:8]` is the prescale factor and line i is numbered as described in R6.
- R3: Only a rising edge of a line counts as an assertion. A line held high gives exactly one count and at most one trigger.
- R4: A prescale factor N passes every Nth enabled edge of its line, and N=0 behaves as N=1. Writing a line's configuration restarts its prescale phase.
- R5: Each line's counter increments on every enabled rising edge, before prescaling. It saturates at all-ones. Any write to `0x200+i` clears counter i, and a clear wins over a same-cycle increment. `cnt_value` shows the counter chosen by `cnt_sel`.
- R6: Lines are numbered as follows: 0..29 are `bp_trig`, 30..59 are `ext_trig` and 60..74 are `fp_trig`. Slice k covers lines 5k..5k+4, with line 5k as the LSB of the address. Slices 0-5 belong to the backplane group, 6-11 to the external group and 12-14 to the front-panel group. A group fires when any of its post-prescale bits is set. Its code is the OR of `table[k][addr]` over its slices with non-zero address.
- R7: When several sources fire in the same cycle, the priority is software, then backplane, then external, then front panel.
- R8: An input edge that is present before clock edge k produces a one-cycle `evt_valid` after clock edge k+1. `evt_type` is valid in that same cycle and is 0 whenever `evt_valid` is 0.
- R9: Table entry e of slice k is written at address `0x400 + 32*k + e`, with `wr_data[9:0]`. Such writes are ignored while the run bit is set. The run bit is `wr_data[0]` written to address `0x000`.
- R10: A `sw_trig` pulse produces an event with type `sw_type`, with the same two-edge latency as a line edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Synchronous active-high reset |
| bp_trig | input | 30 | Backplane trigger lines |
| ext_trig | input | 30 | External front-panel trigger lines |
| fp_trig | input | 15 | Further front-panel trigger lines |
| sw_trig | input | 1 | Software trigger strobe |
| sw_type | input | 10 | Type carried by the software trigger |
| wr_en | input | 1 | Register/table write strobe |
| wr_addr | input | 12 | Write address |
| wr_data | input | 32 | Write data |
| cnt_sel | input | 7 | Counter select |
| cnt_value | output | CNT_W | Selected line counter |
| evt_valid | output | 1 | Event strobe |
| evt_type | output | 10 | Event-type code |

## Verification
Two conditions are hard to reach from the ports. The first is counter saturation, because a 32-bit counter cannot be filled in a bench run. The bench therefore builds the block with a narrow counter width and toggles one line a few hundred times. The second is a same-cycle collision of several sources while each prescaler is at a different phase. To reach it, random phases drive sparse random patterns on all 75 lines with mixed prescale factors and occasional software triggers. Directed phases isolate prescaling, held levels, disabled lines and table locking.

// File: rtl/trig_enc_pkg.sv
package trig_enc_pkg;
    localparam int TYPE_W   = 10;
    localparam int SLICE_W  = 5;
    localparam int NUM_BP   = 30;
    localparam int NUM_EXT  = 30;
    localparam int NUM_FP   = 15;
    localparam int NUM_LINES  = NUM_BP + NUM_EXT + NUM_FP;
    localparam int NUM_SLICES = NUM_LINES / SLICE_W;
    localparam int BP_SLICES  = NUM_BP / SLICE_W;
    localparam int EXT_SLICES = NUM_EXT / SLICE_W;
    localparam int TBL_DEPTH  = 1 << SLICE_W;

    typedef struct packed {
        logic              run;
        logic              sw;
        logic [TYPE_W-1:0] swt;
        logic              vld;
        logic [TYPE_W-1:0] typ;
    } enc_state_t;
endpackage

// File: rtl/trig_line.sv
module trig_line #(
    parameter int CNT_W = 32,
    parameter int PS_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_bit,
    input  logic             cfg_we,
    input  logic             cfg_en,
    input  logic [PS_W-1:0]  cfg_ps,
    input  logic             clr,
    output logic             pulse,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic             en;
        logic [PS_W-1:0]  ps;
        logic             prev;
        logic [PS_W-1:0]  psc;
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } line_t;

    line_t q, d;
    logic        rise;
    logic [PS_W:0] lim;
    logic [PS_W:0] nxt;

    always_comb begin
        d     = q;
        d.prev  = in_bit;
        d.pulse = 1'b0;
        rise  = in_bit & ~q.prev & q.en;
        lim   = (q.ps == '0) ? (PS_W+1)'(1) : {1'b0, q.ps};
        nxt   = {1'b0, q.psc} + (PS_W+1)'(1);
        if (rise) begin
            if (q.cnt != '1) d.cnt = q.cnt + 1'b1;
            if (nxt >= lim) begin
                d.pulse = 1'b1;
                d.psc   = '0;
            end else begin
                d.psc = nxt[PS_W-1:0];
            end
        end
        if (clr) d.cnt = '0;
        if (cfg_we) begin
            d.en  = cfg_en;
            d.ps  = cfg_ps;
            d.psc = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign pulse = q.pulse;
    assign count = q.cnt;
endmodule

// File: rtl/type_table.sv
module type_table #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 10,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [DATA_W-1:0]       rdata,
    output logic [DEPTH*DATA_W-1:0] contents
);
    logic [DEPTH-1:0][DATA_W-1:0] mem_q, mem_d;

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) mem_q <= '0;
        else     mem_q <= mem_d;
    end

    assign rdata    = mem_q[raddr];
    assign contents = mem_q;
endmodule

// File: rtl/trig_type_encoder.sv
module trig_type_encoder
    import trig_enc_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PS_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_BP-1:0]  bp_trig,
    input  logic [NUM_EXT-1:0] ext_trig,
    input  logic [NUM_FP-1:0]  fp_trig,
    input  logic              sw_trig,
    input  logic [TYPE_W-1:0] sw_type,
    input  logic              wr_en,
    input  logic [11:0]       wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [6:0]        cnt_sel,
    output logic [CNT_W-1:0]  cnt_value,
    output logic              evt_valid,
    output logic [TYPE_W-1:0] evt_type
);
    localparam int TBL_BITS = TBL_DEPTH * TYPE_W;

    enc_state_t q, d;

    logic [NUM_LINES-1:0] lines;
    logic [NUM_LINES-1:0] pulse_q;
    logic [CNT_W-1:0]     cnt_all [NUM_LINES];
    logic [TYPE_W-1:0]    slice_code [NUM_SLICES];
    logic [NUM_SLICES*TBL_BITS-1:0] tbl_flat;
    logic                 tbl_sel;
    logic [TYPE_W-1:0]    code_bp, code_ext, code_fp;
    logic                 any_pulse;
    logic                 sw_q;
    logic [TYPE_W-1:0]    sw_type_q;
    logic                 run_q;

    assign lines   = {fp_trig, ext_trig, bp_trig};
    assign tbl_sel = wr_en && (wr_addr[11:9] == 3'b010) && !q.run;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        trig_line #(.CNT_W(CNT_W), .PS_W(PS_W)) u_line (
            .clk    (clk),
            .rst    (rst),
            .in_bit (lines[i]),
            .cfg_we (wr_en && wr_addr[11:8] == 4'h1 && wr_addr[7:0] == 8'(i)),
            .cfg_en (wr_data[0]),
            .cfg_ps (wr_data[8 +: PS_W]),
            .clr    (wr_en && wr_addr[11:8] == 4'h2 && wr_addr[7:0] == 8'(i)),
            .pulse  (pulse_q[i]),
            .count  (cnt_all[i])
        );
    end

    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
        logic [TYPE_W-1:0] rd;
        type_table #(.ADDR_W(SLICE_W), .DATA_W(TYPE_W)) u_tbl (
            .clk      (clk),
            .rst      (rst),
            .we       (tbl_sel && wr_addr[8:5] == 4'(k)),
            .waddr    (wr_addr[4:0]),
            .wdata    (wr_data[TYPE_W-1:0]),
            .raddr    (pulse_q[k*SLICE_W +: SLICE_W]),
            .rdata    (rd),
            .contents (tbl_flat[k*TBL_BITS +: TBL_BITS])
        );
        assign slice_code[k] = (|pulse_q[k*SLICE_W +: SLICE_W]) ? rd : '0;
    end

    always_comb begin
        code_bp  = '0;
        code_ext = '0;
        code_fp  = '0;
        for (int k = 0; k < NUM_SLICES; k++) begin
            if (k < BP_SLICES)                   code_bp  |= slice_code[k];
            else if (k < BP_SLICES + EXT_SLICES) code_ext |= slice_code[k];
            else                                 code_fp  |= slice_code[k];
        end
    end

    always_comb begin
        d     = q;
        d.sw  = sw_trig;
        d.swt = sw_type;
        d.vld = 1'b1;
        if (q.sw)                                  d.typ = q.swt;
        else if (|pulse_q[NUM_BP-1:0])             d.typ = code_bp;
        else if (|pulse_q[NUM_BP+NUM_EXT-1:NUM_BP]) d.typ = code_ext;
        else if (|pulse_q[NUM_LINES-1:NUM_BP+NUM_EXT]) d.typ = code_fp;
        else begin
            d.vld = 1'b0;
            d.typ = '0;
        end
        if (wr_en && wr_addr == 12'h000) d.run = wr_data[0];
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign any_pulse = |pulse_q;
    assign sw_q      = q.sw;
    assign sw_type_q = q.swt;
    assign run_q     = q.run;
    assign evt_valid = q.vld;
    assign evt_type  = q.typ;
    assign cnt_value = (cnt_sel < 7'(NUM_LINES)) ? cnt_all[cnt_sel] : '0;
endmodule

// File: rtl/trig_type_encoder_chk.sv
module trig_type_encoder_chk
    import trig_enc_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int TBLW  = 4800
) (
    input logic              clk,
    input logic              rst,
    input logic              evt_valid,
    input logic [TYPE_W-1:0] evt_type,
    input logic              sw_q,
    input logic [TYPE_W-1:0] sw_type_q,
    input logic              any_pulse,
    input logic              run_q,
    input logic              wr_en,
    input logic [11:0]       wr_addr,
    input logic [6:0]        cnt_sel,
    input logic [CNT_W-1:0]  cnt_value,
    input logic [TBLW-1:0]   tbl_flat
);
    p_strobe_has_cause_r8: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> $past(sw_q || any_pulse));

    p_type_zero_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !evt_valid |-> evt_type == '0);

    p_sw_wins_r10: assert property (@(posedge clk) disable iff (rst)
        sw_q |=> evt_valid && evt_type == $past(sw_type_q));

    p_count_no_drop_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(cnt_sel) == cnt_sel &&
         !$past(wr_en && wr_addr[11:8] == 4'h2)) |-> cnt_value >= $past(cnt_value));

    p_table_locked_r9: assert property (@(posedge clk) disable iff (rst)
        (run_q && wr_en && wr_addr[11:9] == 3'b010) |=> $stable(tbl_flat));
endmodule

bind trig_type_encoder trig_type_encoder_chk #(
    .CNT_W(CNT_W),
    .TBLW (trig_enc_pkg::NUM_SLICES * trig_enc_pkg::TBL_DEPTH * trig_enc_pkg::TYPE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_valid (evt_valid),
    .evt_type  (evt_type),
    .sw_q      (sw_q),
    .sw_type_q (sw_type_q),
    .any_pulse (any_pulse),
    .run_q     (run_q),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .cnt_sel   (cnt_sel),
    .cnt_value (cnt_value),
    .tbl_flat  (tbl_flat)
);

// File: tb/trig_type_encoder_bench.sv
`timescale 1ns/1ps
module trig_type_encoder_bench;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [29:0] bp_trig = '0, ext_trig = '0;
    logic [14:0] fp_trig = '0;
    logic sw_trig = 1'b0;
    logic [9:0] sw_type = '0;
    logic wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [6:0] cnt_sel = '0;
    logic [CW-1:0] cnt_value;
    logic evt_valid;
    logic [9:0] evt_type;

    trig_type_encoder #(.CNT_W(CW), .PS_W(8)) u_trig_type_encoder (
        .clk(clk), .rst(rst), .bp_trig(bp_trig), .ext_trig(ext_trig),
        .fp_trig(fp_trig), .sw_trig(sw_trig), .sw_type(sw_type),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_sel(cnt_sel), .cnt_value(cnt_value),
        .evt_valid(evt_valid), .evt_type(evt_type));

    always #2.5 clk = ~clk;

    int errors = 0, checks = 0;
    int strobes = 0;
    logic [9:0] last_typ;

    // reference model state
    logic [74:0] m_en = '0, m_prev = '0, m_pulse = '0;
    int m_ps[75], m_psc[75], m_cnt[75];
    logic [9:0] m_tbl[15][32];
    bit m_run = 0, m_sw = 0;
    logic [9:0] m_swt = '0;
    bit e_vld = 0;
    logic [9:0] e_typ = '0;
    string e_tag = "R8";

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] grp_code(input logic [74:0] p, input int s0, input int s1);
        logic [9:0] c = '0;
        for (int k = s0; k < s1; k++)
            if (p[k*5 +: 5] != 0) c |= m_tbl[k][p[k*5 +: 5]];
        return c;
    endfunction

    task automatic step(input logic [29:0] bp, input logic [29:0] ext, input logic [14:0] fp,
                        input bit sw, input logic [9:0] swt,
                        input bit we, input logic [11:0] wa, input logic [31:0] wd);
        logic [74:0] ln, np;
        bit nv;
        logic [9:0] nt;
        string ntag;
        check(evt_valid == e_vld, "R8", int'(evt_valid), int'(e_vld));
        check(evt_type == e_typ, e_tag, int'(evt_type), int'(e_typ));
        if (evt_valid) begin strobes++; last_typ = evt_type; end
        bp_trig = bp; ext_trig = ext; fp_trig = fp; sw_trig = sw; sw_type = swt;
        wr_en = we; wr_addr = wa; wr_data = wd;
        // output stage from current pulses
        nv = 1; ntag = "R6";
        if ((m_sw ? 1 : 0) + (m_pulse[29:0] != 0) + (m_pulse[59:30] != 0) + (m_pulse[74:60] != 0) > 1)
            ntag = "R7";
        if (m_sw) begin nt = m_swt; ntag = "R10"; end
        else if (m_pulse[29:0] != 0)  nt = grp_code(m_pulse, 0, 6);
        else if (m_pulse[59:30] != 0) nt = grp_code(m_pulse, 6, 12);
        else if (m_pulse[74:60] != 0) nt = grp_code(m_pulse, 12, 15);
        else begin nv = 0; nt = '0; ntag = "R8"; end
        // line stage
        ln = {fp, ext, bp};
        np = '0;
        for (int i = 0; i < 75; i++) begin
            if (ln[i] && !m_prev[i] && m_en[i]) begin
                int lim = (m_ps[i] == 0) ? 1 : m_ps[i];
                if (m_cnt[i] < (1 << CW) - 1) m_cnt[i]++;
                if (m_psc[i] + 1 >= lim) begin np[i] = 1; m_psc[i] = 0; end
                else m_psc[i]++;
            end
        end
        m_prev = ln;
        if (we) begin
            if (wa == 12'h000) m_run = wd[0];
            else if (wa[11:8] == 4'h1 && wa[7:0] < 75) begin
                m_en[wa[7:0]] = wd[0]; m_ps[wa[7:0]] = int'(wd[15:8]); m_psc[wa[7:0]] = 0;
            end else if (wa[11:8] == 4'h2 && wa[7:0] < 75) m_cnt[wa[7:0]] = 0;
            else if (wa[11:9] == 3'b010 && wa[8:5] < 15 && !m_run) m_tbl[wa[8:5]][wa[4:0]] = wd[9:0];
        end
        m_sw = sw; m_swt = swt;
        @(posedge clk);
        m_pulse = np; e_vld = nv; e_typ = nt; e_tag = ntag;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, '0, '0, 0, '0, 0, '0, '0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step('0, '0, '0, 0, '0, 1, a, d);
    endtask

    task automatic read_cnt(input int i, input string tag);
        cnt_sel = 7'(i);
        #0.5;
        check(int'(cnt_value) == m_cnt[i], tag, int'(cnt_value), m_cnt[i]);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int s0;
        logic [9:0] old_v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 75; i++) begin m_ps[i] = 0; m_psc[i] = 0; m_cnt[i] = 0; end
        for (int k = 0; k < 15; k++) for (int e = 0; e < 32; e++) m_tbl[k][e] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(evt_valid == 0, "R1", int'(evt_valid), 0);
        read_cnt(0, "R1"); read_cnt(74, "R1");

        for (int k = 0; k < 15; k++)
            for (int e = 1; e < 32; e++) wr(12'h400 + 12'(k*32 + e), 32'($urandom) & 32'h3ff);

        // R4: prescale 3 on line 0, prescale 0 on line 1
        wr(12'h100, 32'h0301);
        s0 = strobes;
        for (int i = 0; i < 9; i++) begin step(30'h1, '0, '0, 0, '0, 0, '0, '0); idle(1); end
        idle(2);
        check(strobes - s0 == 3, "R4", strobes - s0, 3);
        wr(12'h101, 32'h0001);
        s0 = strobes;
        for (int i = 0; i < 4; i++) begin step(30'h2, '0, '0, 0, '0, 0, '0, '0); idle(1); end
        idle(2);
        check(strobes - s0 == 4, "R4", strobes - s0, 4);
        read_cnt(0, "R5");

        // R3: held level counts once
        wr(12'h13c, 32'h0101);
        s0 = strobes;
        for (int i = 0; i < 10; i++) step('0, '0, 15'h1, 0, '0, 0, '0, '0);
        idle(3);
        check(strobes - s0 == 1, "R3", strobes - s0, 1);
        read_cnt(60, "R3");
        check(m_cnt[60] == 1, "R3", m_cnt[60], 1);

        // R2: disabled line has no effect
        wr(12'h100, 32'h0);
        wr(12'h101, 32'h0);
        wr(12'h13c, 32'h0);
        s0 = strobes;
        for (int i = 0; i < 5; i++) begin step(30'h3, '0, 15'h1, 0, '0, 0, '0, '0); idle(1); end
        idle(2);
        check(strobes - s0 == 0, "R2", strobes - s0, 0);
        read_cnt(0, "R2");

        // random configuration and traffic (R6, R7, R10)
        for (int i = 0; i < 75; i++)
            wr(12'h100 + 12'(i), {16'h0, 8'($urandom_range(0, 3)), 7'h0, 1'(($urandom & 3) != 0)});
        for (int c = 0; c < 3000; c++) begin
            bit we = ($urandom & 63) == 0;
            step(30'($urandom & $urandom & $urandom), 30'($urandom & $urandom & $urandom),
                 15'($urandom & $urandom & $urandom), ($urandom & 15) == 0, 10'($urandom),
                 we, 12'h200 + 12'($urandom_range(0, 74)), '0);
        end
        idle(2);
        for (int i = 0; i < 75; i++) read_cnt(i, m_en[i] ? "R5" : "R2");

        // R5: saturation and clear
        for (int i = 0; i < 75; i++) wr(12'h100 + 12'(i), 32'h0);
        wr(12'h24a, 32'h0);
        wr(12'h14a, 32'h0101);
        for (int i = 0; i < 300; i++) begin step('0, '0, 15'h4000, 0, '0, 0, '0, '0); idle(1); end
        idle(2);
        read_cnt(74, "R5");
        check(int'(cnt_value) == 255, "R5", int'(cnt_value), 255);
        wr(12'h24a, 32'h0);
        read_cnt(74, "R5");

        // R9: table locked while running
        wr(12'h100, 32'h0101);
        old_v = m_tbl[0][1];
        wr(12'h000, 32'h1);
        wr(12'h401, {22'h0, ~old_v});
        step(30'h1, '0, '0, 0, '0, 0, '0, '0);
        idle(3);
        check(last_typ == old_v, "R9", int'(last_typ), int'(old_v));
        wr(12'h000, 32'h0);
        wr(12'h401, {22'h0, ~old_v});
        step(30'h1, '0, '0, 0, '0, 0, '0, '0);
        idle(3);
        check(last_typ == ~old_v, "R9", int'(last_typ), int'(~old_v));

        // R7/R10: software and all groups at once
        wr(12'h11e, 32'h0101);
        wr(12'h13c, 32'h0101);
        step(30'h1, 30'h1, 15'h1, 1, 10'h2a5, 0, '0, '0);
        idle(3);
        check(last_typ == 10'h2a5, "R10", int'(last_typ), 'h2a5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule